// File: doc/BRIEF.md
# Dual Modulo-K Counter Loop Filter

This block is the loop filter stage of an all-digital phase-locked loop. It holds two independent counters that both count only upward and are both clocked by a fast filter clock. That clock typically runs 8, 16 or 32 times the loop centre frequency. A direction input from the phase detector picks which counter advances on each clock; the other one holds its value. The most significant bit of the active counting range of each counter is brought out as a level: carry from one counter, borrow from the other. Every rising edge of either level is also reported as a one-cycle pulse. A downstream digitally controlled oscillator uses these pulses to add or drop phase steps.

The modulus K is always a power of two. It is selected by a code equal to log2(K), from 1 up to the counter width. The code is captured only on a synchronous clear, so a running loop never sees a partial change of modulus. Codes outside the legal range are clamped to the nearest legal value.

Top module: `kcnt_loop_filter`

## Requirements
- R1: After the asynchronous reset rst_ni, both counts are zero, all four outputs are low, and the modulus code is CNT_W, so K = 2^CNT_W.
- R2: Each counter takes values 0 to K-1 and returns to 0 on the step after K-1. While one counter advances without interruption, its MSB output is high for exactly K/2 of every K cycles.
- R3: With dn_sel_i low, the carry counter advances by one per clock and the borrow counter holds its value.
- R4: With dn_sel_i high, the borrow counter advances by one per clock and the carry counter holds its value.
- R5: carry_o is high exactly when the carry count is at least K/2.
- R6: borrow_o is high exactly when the borrow count is at least K/2.
- R7: carry_pulse_o (or borrow_pulse_o) is high for exactly one cycle, in the cycle that follows the first cycle in which carry_o (or borrow_o) is high after being low. It is never high in two consecutive cycles.
- R8: When clear_i is high at a clock edge, both counts, both pulses and the edge history are zeroed, and mod_sel_i is captured as the new log2(K). At any other time, a change on mod_sel_i has no effect.
- R9: On capture, a code of 0 is taken as 1 (K = 2), and a code above CNT_W is taken as CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter clock (M times loop centre frequency) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous clear; also loads the modulus code |
| dn_sel_i | input | 1 | High: borrow counter advances; low: carry counter advances |
| mod_sel_i | input | MODW | log2(K) code, 1..CNT_W |
| carry_o | output | 1 | MSB of the carry counter |
| borrow_o | output | 1 | MSB of the borrow counter |
| carry_pulse_o | output | 1 | One-cycle pulse after each carry rise |
| borrow_pulse_o | output | 1 | One-cycle pulse after each borrow rise |

## Verification
The bench goes after the extremes of the modulus. At K = 2 the MSB toggles every step, so a design that mishandled pulse timing would emit pulses on back-to-back cycles. At K = 2^CNT_W, a mask built from a shift that overflows would make the counter stick or wrap early. It also drives illegal codes 0 and above CNT_W: a design without clamping would select a nonexistent MSB and never raise carry. It changes mod_sel_i with no clear, where a design that loads the code continuously would shift its carry period. Long runs with random direction patterns would expose a design that let the idle counter creep or that tapped the wrong bit.

// File: rtl/kcnt_pkg.sv
package kcnt_pkg;

  // Clamp a requested log2(K) code to the legal range 1..max_w
  function automatic int unsigned clamp_log2k(int unsigned code, int unsigned max_w);
    if (code == 0) return 1;
    if (code > max_w) return max_w;
    return code;
  endfunction

endpackage

// File: rtl/kcnt_mod_reg.sv
module kcnt_mod_reg #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned MODW  = $clog2(CNT_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic [MODW-1:0] mod_sel_i,
  output logic [MODW-1:0] log2k_o
);
  import kcnt_pkg::*;

  logic [MODW-1:0] log2k_q;
  logic [MODW-1:0] log2k_d;

  always_comb log2k_d = MODW'(clamp_log2k(int'(mod_sel_i), CNT_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      log2k_q <= MODW'(CNT_W);
    else if (clear_i) log2k_q <= log2k_d;
  end

  assign log2k_o = log2k_q;

  // R8
  mod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> $stable(log2k_q));

  // R9
  mod_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log2k_q >= MODW'(1)) && (log2k_q <= MODW'(CNT_W)));

endmodule

// File: rtl/kcnt_counter.sv
module kcnt_counter #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned MODW  = $clog2(CNT_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            en_i,
  input  logic [MODW-1:0] log2k_i,
  output logic            msb_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] top_bit;

  // mask = K-1; top_bit selects bit log2(K)-1
  always_comb begin
    mask    = {CNT_W{1'b1}} >> (MODW'(CNT_W) - log2k_i);
    top_bit = mask & ~(mask >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= (cnt_q + CNT_W'(1)) & mask;
  end

  assign msb_o = |(cnt_q & top_bit);

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q & ~mask) == '0);

  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && cnt_q == mask) |=> cnt_q == '0);

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/kcnt_edge_det.sv
module kcnt_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic lvl_i,
  output logic pulse_o
);
  logic prev_q;
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (clear_i) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      pulse_q <= lvl_i & ~prev_q;
    end
  end

  assign pulse_o = pulse_q;

  // R7
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  // R7
  pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(lvl_i));

endmodule

// File: rtl/kcnt_loop_filter.sv
module kcnt_loop_filter #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned MODW  = $clog2(CNT_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            dn_sel_i,
  input  logic [MODW-1:0] mod_sel_i,
  output logic            carry_o,
  output logic            borrow_o,
  output logic            carry_pulse_o,
  output logic            borrow_pulse_o
);
  localparam int unsigned NCNT = 2;

  logic [MODW-1:0] log2k;
  logic [NCNT-1:0] en;
  logic [NCNT-1:0] msb;
  logic [NCNT-1:0] pulse;

  kcnt_mod_reg #(.CNT_W(CNT_W), .MODW(MODW)) u_mod (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .mod_sel_i (mod_sel_i),
    .log2k_o   (log2k)
  );

  // index 0: carry counter (dir low), index 1: borrow counter (dir high)
  assign en = {dn_sel_i, ~dn_sel_i};

  for (genvar g = 0; g < NCNT; g++) begin : g_chan
    kcnt_counter #(.CNT_W(CNT_W), .MODW(MODW)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .en_i    (en[g]),
      .log2k_i (log2k),
      .msb_o   (msb[g])
    );
    kcnt_edge_det u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .lvl_i   (msb[g]),
      .pulse_o (pulse[g])
    );
  end

  assign carry_o        = msb[0];
  assign borrow_o       = msb[1];
  assign carry_pulse_o  = pulse[0];
  assign borrow_pulse_o = pulse[1];

  // R3
  carry_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_sel_i && !clear_i) |=> $stable(carry_o));

  // R4
  borrow_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dn_sel_i && !clear_i) |=> $stable(borrow_o));

  // R8
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !carry_o && !borrow_o && !carry_pulse_o && !borrow_pulse_o);

endmodule

// File: tb/kcnt_loop_filter_tb_top.sv
module kcnt_loop_filter_tb_top;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned MODW  = $clog2(CNT_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic dn_sel = 1'b0;
  logic [MODW-1:0] mod_sel = '0;
  logic carry, borrow, carry_p, borrow_p;

  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  kcnt_loop_filter #(.CNT_W(CNT_W), .MODW(MODW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .dn_sel_i(dn_sel),
    .mod_sel_i(mod_sel), .carry_o(carry), .borrow_o(borrow),
    .carry_pulse_o(carry_p), .borrow_pulse_o(borrow_p)
  );

  // reference model
  int unsigned m_up, m_dn, m_l;
  logic m_cprev, m_bprev, m_cp, m_bp;

  function automatic int unsigned ref_clamp(int unsigned c);
    if (c == 0) return 1;
    if (c > CNT_W) return CNT_W;
    return c;
  endfunction

  function automatic logic ref_msb(int unsigned v, int unsigned l);
    return ((v >> (l - 1)) & 1) != 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_up = 0; m_dn = 0; m_l = CNT_W;
      m_cprev = 0; m_bprev = 0; m_cp = 0; m_bp = 0;
    end else if (clear) begin
      m_up = 0; m_dn = 0; m_l = ref_clamp(int'(mod_sel));
      m_cprev = 0; m_bprev = 0; m_cp = 0; m_bp = 0;
    end else begin
      logic c, b;
      c = ref_msb(m_up, m_l);
      b = ref_msb(m_dn, m_l);
      m_cp = c & ~m_cprev; m_cprev = c;
      m_bp = b & ~m_bprev; m_bprev = b;
      if (dn_sel) m_dn = (m_dn + 1) % (1 << m_l);
      else        m_up = (m_up + 1) % (1 << m_l);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // every cycle, away from the active edge
  bit run_chk = 0;
  always @(negedge clk) if (run_chk && rst_n) begin
    chk("R3 R5 carry_o", carry, ref_msb(m_up, m_l));
    chk("R4 R6 borrow_o", borrow, ref_msb(m_dn, m_l));
    chk("R7 carry_pulse_o", carry_p, m_cp);
    chk("R7 borrow_pulse_o", borrow_p, m_bp);
  end

  task automatic do_clear(int unsigned code);
    @(negedge clk);
    clear = 1'b1; mod_sel = MODW'(code);
    @(negedge clk);
    clear = 1'b0;
  endtask

  // Run n cycles in one direction, count high cycles of the MSB
  task automatic run_dir(logic d, int n, output int hi, output int pulses);
    hi = 0; pulses = 0;
    dn_sel = d;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((d ? borrow : carry) === 1'b1) hi++;
      if ((d ? borrow_p : carry_p) === 1'b1) pulses++;
    end
  endtask

  initial begin
    int hi, np;
    void'($urandom(32'h5eed_1234));
    #1;
    // R1 reset state
    chk("R1 carry_o", carry, 1'b0);
    chk("R1 borrow_o", borrow, 1'b0);
    chk("R1 carry_pulse_o", carry_p, 1'b0);
    chk("R1 borrow_pulse_o", borrow_p, 1'b0);
    #22 rst_n = 1'b1;
    run_chk = 1;
    // R1: default K = 256; R2 full-range duty
    run_dir(1'b0, 512, hi, np);
    n_tests++; if (hi != 256 || np != 2) begin n_fail++;
      $display("FAIL R1 R2 default K hi=%0d pulses=%0d expected 256/2", hi, np); end
    // R2 K=2, R7 alternate pulses
    do_clear(1);
    run_dir(1'b1, 20, hi, np);
    n_tests++; if (hi != 10 || np != 10) begin n_fail++;
      $display("FAIL R2 R7 K=2 hi=%0d pulses=%0d expected 10/10", hi, np); end
    // R3 carry held while borrow ran
    n_tests++; if (carry !== 1'b0) begin n_fail++;
      $display("FAIL R4 carry moved actual=%0b expected=0", carry); end
    // R9 code 0 -> 1
    do_clear(0);
    run_dir(1'b0, 8, hi, np);
    n_tests++; if (hi != 4) begin n_fail++;
      $display("FAIL R9 code0 hi=%0d expected 4", hi); end
    // R9 code 15 -> CNT_W
    do_clear(15);
    run_dir(1'b0, 256, hi, np);
    n_tests++; if (hi != 128 || np != 1) begin n_fail++;
      $display("FAIL R9 code15 hi=%0d pulses=%0d expected 128/1", hi, np); end
    // R8 mod change without clear ignored
    do_clear(3);
    mod_sel = MODW'(1);
    run_dir(1'b0, 16, hi, np);
    n_tests++; if (hi != 8 || np != 2) begin n_fail++;
      $display("FAIL R8 unclr mod hi=%0d pulses=%0d expected 8/2", hi, np); end
    // R8 clear zeroes counts mid-run
    run_dir(1'b1, 5, hi, np);
    do_clear(3);
    chk("R8 borrow_o after clear", borrow, 1'b0);
    chk("R8 carry_o after clear", carry, 1'b0);
    // random phase with random direction and occasional clear
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      dn_sel = $urandom_range(0, 1) == 1;
      mod_sel = MODW'($urandom_range(0, 15));
      clear = ($urandom_range(0, 199) == 0);
    end
    @(negedge clk); clear = 1'b0;
    repeat (4) @(negedge clk);
    run_chk = 0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule